// File: doc/BRIEF.md
# Indirect Pattern Detector

This block learns how an index value read by a load is linked to the address of a later cache miss. The usual case is an indirect array access `A[B[i]]`, where the missing address is `base + (index << shift)`. An owning prefetch-table entry presents an index event, made of its owner id and the index value. The detector keeps a small fully associative table keyed by owner. It follows one entry at a time and records the misses that come after that entry's first index. For each recorded miss it computes one candidate base per shift in a fixed candidate set.

When a second index arrives for the same owner, each later miss is turned into one fresh candidate per shift, using the second index. These are compared with the candidates that were stored before. A candidate that recurs with the same shift is reported to the owner as a learn result: the owner id, the base and the shift. The detector entry is then released. If a third index arrives before any match, the attempt is abandoned and the entry is released. Issuing prefetches is left to the owner.

The compare runs over several cycles, one stored miss slot per cycle, and the block raises `busy` while it does so. Events that arrive while `busy` is high are dropped. The caller is expected to present events only when `busy` is low.

Top module: `ipd_detector`

## Requirements
- R1: After reset `busy` and `learn_valid` are low and no owner has an entry.
- R2: An index event whose owner has no entry allocates an entry. The entry is the lowest-numbered empty one, or the least recently used one if none is empty. The event stores the index as the first index, with no miss slots, and makes this entry the only one that tracks misses.
- R3: While the tracked entry has no second index, each miss fills the next free slot with four candidates `miss - sh(idx1, s)`, in shift order code 0..3 = shifts 2, 3, 4, -3. `sh` sign-extends the 16-bit index. A positive shift is a left shift; -3 is an arithmetic right shift by 3. After the fourth slot is filled, tracking stops and further misses are ignored.
- R4: An index event for an owner whose entry has only a first index stores the second index and makes that entry the tracked one again. The filled slots are kept.
- R5: A miss on a tracked entry that has a second index and at least one filled slot starts a scan. `busy` goes high from the next cycle. Each cycle compares one slot, in increasing slot order, with the new candidates `miss - sh(idx2, s)`, comparing each shift with the same shift only. On the first match, with the lowest slot first and then the lowest shift code, `learn_valid` pulses for one cycle with the owner, the base and the shift as a 4-bit two's-complement value. At the same time `busy` falls, the entry is released and tracking stops. A match in slot j keeps `busy` high for j+1 cycles. Without a match, `busy` stays high for as many cycles as there are filled slots, and the entry is kept.
- R6: An index event for an owner whose entry already holds a second index releases that entry and stops all tracking. A later index event for that owner allocates afresh as a first index.
- R7: Only one entry tracks misses at a time. Misses that arrive while no entry is tracked have no effect.
- R8: While `busy` is high, index and miss events are ignored.
- R9: When an index event and a miss arrive in the same cycle, the index event is processed and the miss is dropped.
- R10: Every accepted index event makes its entry the most recently used. Replacement evicts the least recently used of the four entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_valid | input | 1 | Index event strobe |
| idx_owner | input | OWNER_W (4) | Owning prefetch-table entry id |
| idx_value | input | IDX_W (16) | Index value, signed |
| miss_valid | input | 1 | Cache-miss strobe |
| miss_addr | input | ADDR_W (32) | Miss address |
| busy | output | 1 | Compare scan in progress; inputs ignored |
| learn_valid | output | 1 | One-cycle learn result strobe |
| learn_owner | output | OWNER_W (4) | Owner the result belongs to |
| learn_base | output | ADDR_W (32) | Learned base address |
| learn_shift | output | 4 | Learned shift, two's complement (2, 3, 4 or -3) |

## Verification
The bench targets several corner cases, and each one shows how a faulty design would fail:
- Two shifts that produce the same base: a design that does not favour the lowest slot and shift reports the wrong shift.
- A negative index under the -3 shift: a logical shift gives a wrong base.
- A fifth miss: a design that keeps recording it learns a base it should not learn.
- A third index: a design that fails to release the entry still learns afterwards.
- An index event and a miss in the same cycle: a design that keeps the miss fills a slot, and the following miss then learns.
- An event injected during a scan: a design that accepts it releases the entry, and the pending learn is lost.
- The LRU case, where an entry was touched again just before an eviction: a naive replacement loses the wrong owner.

The `busy` length is checked against the slot in which the match was found.

// File: rtl/ipd_pkg.sv
package ipd_pkg;
   // Fixed candidate shift set, searched in code order 0..NUM_SHIFTS-1.
   localparam int NUM_SHIFTS = 4;
   localparam int SHIFT_W    = 4;

   function automatic int shift_amt(input int code);
      case (code)
         0:       return 2;
         1:       return 3;
         2:       return 4;
         default: return -3;
      endcase
   endfunction
endpackage

// File: rtl/ipd_cand_gen.sv
// Candidate bases: addr - sh(idx, s) for every shift in the set.
module ipd_cand_gen
   import ipd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 16
) (
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [IDX_W-1:0]                   idx,
   output logic [NUM_SHIFTS-1:0][ADDR_W-1:0]  cand
);
   localparam int EXT_W = ADDR_W - IDX_W;

   logic signed [ADDR_W-1:0] idx_ext;
   assign idx_ext = {{EXT_W{idx[IDX_W-1]}}, idx};

   for (genvar k = 0; k < NUM_SHIFTS; k++) begin : g_shift
      localparam int S = shift_amt(k);
      logic [ADDR_W-1:0] scaled;
      if (S >= 0) begin : g_left
         assign scaled = idx_ext <<< S;
      end else begin : g_right
         assign scaled = idx_ext >>> (-S);
      end
      assign cand[k] = addr - scaled;
   end
endmodule

// File: rtl/ipd_match.sv
// Compares one stored slot with the scan candidates, same shift only;
// the lowest shift code wins.
module ipd_match
   import ipd_pkg::*;
#(
   parameter int ADDR_W = 32,
   localparam int KW    = $clog2(NUM_SHIFTS)
) (
   input  logic [NUM_SHIFTS-1:0][ADDR_W-1:0] row,
   input  logic [NUM_SHIFTS-1:0][ADDR_W-1:0] probe,
   output logic                              hit,
   output logic [KW-1:0]                     hit_k
);
   logic [NUM_SHIFTS-1:0] eq;

   for (genvar k = 0; k < NUM_SHIFTS; k++) begin : g_eq
      assign eq[k] = (row[k] == probe[k]);
   end

   always_comb begin
      hit   = |eq;
      hit_k = '0;
      for (int k = NUM_SHIFTS - 1; k >= 0; k--) begin
         if (eq[k]) hit_k = KW'(k);
      end
   end
endmodule

// File: rtl/ipd_lru.sv
// Age-based LRU over N entries; ages stay a permutation of 0..N-1.
module ipd_lru #(
   parameter int N   = 4,
   localparam int AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [AW-1:0] touch_idx,
   input  logic [N-1:0]  valid,
   output logic [AW-1:0] victim
);
   logic [AW-1:0] age [N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) age[i] <= AW'(i);
      end else if (touch) begin
         for (int i = 0; i < N; i++) begin
            if (AW'(i) == touch_idx)          age[i] <= '0;
            else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
         end
      end
   end

   always_comb begin
      victim = '0;
      for (int i = 0; i < N; i++) begin
         if (age[i] == AW'(N - 1)) victim = AW'(i);
      end
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid[i]) victim = AW'(i);
      end
   end

   p_mru_age_r10: assert property (@(posedge clk) disable iff (!rst_n)
      touch |=> age[$past(touch_idx)] == '0);
endmodule

// File: rtl/ipd_detector.sv
module ipd_detector
   import ipd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 16,
   parameter int OWNER_W   = 4,
   parameter int N_ENTRIES = 4,
   parameter int N_SLOTS   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               idx_valid,
   input  logic [OWNER_W-1:0] idx_owner,
   input  logic [IDX_W-1:0]   idx_value,
   input  logic               miss_valid,
   input  logic [ADDR_W-1:0]  miss_addr,
   output logic               busy,
   output logic               learn_valid,
   output logic [OWNER_W-1:0] learn_owner,
   output logic [ADDR_W-1:0]  learn_base,
   output logic [SHIFT_W-1:0] learn_shift
);
   localparam int EW = $clog2(N_ENTRIES);
   localparam int SW = $clog2(N_SLOTS);
   localparam int CW = $clog2(N_SLOTS + 1);
   localparam int KW = $clog2(NUM_SHIFTS);

   if (N_ENTRIES < 2) begin : g_chk_entries
      $error("ipd_detector: N_ENTRIES must be at least 2");
   end
   if (N_SLOTS < 2) begin : g_chk_slots
      $error("ipd_detector: N_SLOTS must be at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_chk_width
      $error("ipd_detector: ADDR_W must exceed IDX_W");
   end

   typedef logic [NUM_SHIFTS-1:0][ADDR_W-1:0] cand_t;

   // Entry storage
   logic [N_ENTRIES-1:0] ent_valid;
   logic [N_ENTRIES-1:0] ent_has2;
   logic [OWNER_W-1:0]   ent_tag   [N_ENTRIES];
   logic [IDX_W-1:0]     ent_idx1  [N_ENTRIES];
   logic [IDX_W-1:0]     ent_idx2  [N_ENTRIES];
   logic [CW-1:0]        ent_nmiss [N_ENTRIES];
   cand_t                ent_cand  [N_ENTRIES][N_SLOTS];

   // Tracking pointer and scan state
   logic          trk_valid;
   logic [EW-1:0] trk_ent;
   logic [SW-1:0] scan_ptr;
   logic [SW-1:0] scan_last;
   cand_t         scan_probe;

   // Owner lookup
   logic          lk_hit;
   logic [EW-1:0] lk_ent;
   always_comb begin
      lk_hit = 1'b0;
      lk_ent = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (ent_valid[i] && ent_tag[i] == idx_owner) begin
            lk_hit = 1'b1;
            lk_ent = EW'(i);
         end
      end
   end

   logic idx_go, miss_go;
   assign idx_go  = idx_valid && !busy;
   assign miss_go = miss_valid && !idx_valid && !busy && trk_valid;

   // Candidate generation for the tracked entry
   logic [IDX_W-1:0] sel_idx;
   cand_t            new_cand;
   assign sel_idx = ent_has2[trk_ent] ? ent_idx2[trk_ent] : ent_idx1[trk_ent];

   ipd_cand_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cand (
      .addr (miss_addr),
      .idx  (sel_idx),
      .cand (new_cand)
   );

   // One slot compared per scan cycle
   logic          m_hit;
   logic [KW-1:0] m_k;
   ipd_match #(.ADDR_W(ADDR_W)) u_match (
      .row   (ent_cand[trk_ent][scan_ptr]),
      .probe (scan_probe),
      .hit   (m_hit),
      .hit_k (m_k)
   );

   // Replacement
   logic [EW-1:0] victim;
   logic [EW-1:0] touch_ent;
   assign touch_ent = lk_hit ? lk_ent : victim;

   ipd_lru #(.N(N_ENTRIES)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch     (idx_go),
      .touch_idx (touch_ent),
      .valid     (ent_valid),
      .victim    (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_valid   <= '0;
         ent_has2    <= '0;
         trk_valid   <= 1'b0;
         trk_ent     <= '0;
         busy        <= 1'b0;
         scan_ptr    <= '0;
         scan_last   <= '0;
         scan_probe  <= '0;
         learn_valid <= 1'b0;
         learn_owner <= '0;
         learn_base  <= '0;
         learn_shift <= '0;
         for (int i = 0; i < N_ENTRIES; i++) begin
            ent_tag[i]   <= '0;
            ent_idx1[i]  <= '0;
            ent_idx2[i]  <= '0;
            ent_nmiss[i] <= '0;
            for (int j = 0; j < N_SLOTS; j++) ent_cand[i][j] <= '0;
         end
      end else begin
         learn_valid <= 1'b0;
         if (busy) begin
            if (m_hit) begin
               learn_valid        <= 1'b1;
               learn_owner        <= ent_tag[trk_ent];
               learn_base         <= scan_probe[m_k];
               learn_shift        <= SHIFT_W'(shift_amt(int'(m_k)));
               ent_valid[trk_ent] <= 1'b0;
               ent_has2[trk_ent]  <= 1'b0;
               trk_valid          <= 1'b0;
               busy               <= 1'b0;
            end else if (scan_ptr == scan_last) begin
               busy <= 1'b0;
            end else begin
               scan_ptr <= scan_ptr + 1'b1;
            end
         end else if (idx_go) begin
            if (lk_hit) begin
               if (!ent_has2[lk_ent]) begin
                  ent_idx2[lk_ent] <= idx_value;
                  ent_has2[lk_ent] <= 1'b1;
                  trk_valid        <= 1'b1;
                  trk_ent          <= lk_ent;
               end else begin
                  ent_valid[lk_ent] <= 1'b0;
                  ent_has2[lk_ent]  <= 1'b0;
                  trk_valid         <= 1'b0;
               end
            end else begin
               ent_valid[victim] <= 1'b1;
               ent_tag[victim]   <= idx_owner;
               ent_idx1[victim]  <= idx_value;
               ent_has2[victim]  <= 1'b0;
               ent_nmiss[victim] <= '0;
               trk_valid         <= 1'b1;
               trk_ent           <= victim;
            end
         end else if (miss_go) begin
            if (!ent_has2[trk_ent]) begin
               ent_cand[trk_ent][SW'(ent_nmiss[trk_ent])] <= new_cand;
               ent_nmiss[trk_ent] <= ent_nmiss[trk_ent] + 1'b1;
               if (ent_nmiss[trk_ent] == CW'(N_SLOTS - 1)) trk_valid <= 1'b0;
            end else if (ent_nmiss[trk_ent] != '0) begin
               busy       <= 1'b1;
               scan_ptr   <= '0;
               scan_last  <= SW'(ent_nmiss[trk_ent] - CW'(1));
               scan_probe <= new_cand;
            end
         end
      end
   end

   p_learn_from_scan_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(learn_valid) |-> $past(busy));

   p_learn_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      learn_valid |=> !learn_valid);

   p_scan_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> scan_ptr <= scan_last);

   p_busy_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !m_hit |=> $stable(ent_valid) && $stable(trk_valid) && $stable(trk_ent));

   p_track_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trk_valid |-> ent_valid[trk_ent]);

   p_track_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trk_valid && !ent_has2[trk_ent] |-> ent_nmiss[trk_ent] < CW'(N_SLOTS));
endmodule

// File: tb/ipd_detector_tb.sv
`timescale 1ns/1ps
module ipd_detector_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        idx_valid;
   logic [3:0]  idx_owner;
   logic [15:0] idx_value;
   logic        miss_valid;
   logic [31:0] miss_addr;
   logic        busy, learn_valid;
   logic [3:0]  learn_owner;
   logic [31:0] learn_base;
   logic [3:0]  learn_shift;

   always #2.5 clk = ~clk;

   ipd_detector u_dut (
      .clk(clk), .rst_n(rst_n),
      .idx_valid(idx_valid), .idx_owner(idx_owner), .idx_value(idx_value),
      .miss_valid(miss_valid), .miss_addr(miss_addr),
      .busy(busy), .learn_valid(learn_valid), .learn_owner(learn_owner),
      .learn_base(learn_base), .learn_shift(learn_shift)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Learn monitor
   int          lcnt = 0;
   logic [3:0]  l_owner;
   logic [31:0] l_base;
   logic [3:0]  l_shift;
   always @(posedge clk) begin
      if (rst_n && learn_valid) begin
         lcnt++;
         l_owner = learn_owner;
         l_base  = learn_base;
         l_shift = learn_shift;
      end
   end

   // Reference model built from the requirements
   bit          m_valid [4];
   bit          m_has2  [4];
   int          m_tag   [4];
   int          m_nmiss [4];
   int          m_age   [4];
   logic [15:0] m_i1    [4];
   logic [15:0] m_i2    [4];
   logic [31:0] m_c     [4][4][4];
   bit          m_trk;
   int          m_te;

   function automatic logic [31:0] shv(input logic [15:0] ix, input int k);
      logic signed [31:0] e;
      e = {{16{ix[15]}}, ix};
      case (k)
         0: return e <<< 2;
         1: return e <<< 3;
         2: return e <<< 4;
         default: return e >>> 3;
      endcase
   endfunction

   function automatic logic [3:0] shcode(input int k);
      case (k)
         0: return 4'd2;
         1: return 4'd3;
         2: return 4'd4;
         default: return 4'hD;
      endcase
   endfunction

   function automatic void m_reset();
      for (int i = 0; i < 4; i++) begin
         m_valid[i] = 0; m_has2[i] = 0; m_age[i] = i; m_nmiss[i] = 0;
      end
      m_trk = 0; m_te = 0;
   endfunction

   function automatic void m_touch(input int e);
      int a;
      a = m_age[e];
      for (int i = 0; i < 4; i++) if (i != e && m_age[i] < a) m_age[i]++;
      m_age[e] = 0;
   endfunction

   function automatic void m_index(input int o, input logic [15:0] ix);
      int h, v;
      h = -1;
      for (int i = 0; i < 4; i++) if (m_valid[i] && m_tag[i] == o && h < 0) h = i;
      if (h >= 0) begin
         m_touch(h);
         if (!m_has2[h]) begin
            m_i2[h] = ix; m_has2[h] = 1; m_trk = 1; m_te = h;
         end else begin
            m_valid[h] = 0; m_has2[h] = 0; m_trk = 0;
         end
      end else begin
         v = -1;
         for (int i = 0; i < 4; i++) if (!m_valid[i] && v < 0) v = i;
         if (v < 0) for (int i = 0; i < 4; i++) if (m_age[i] == 3) v = i;
         m_touch(v);
         m_valid[v] = 1; m_tag[v] = o; m_i1[v] = ix; m_has2[v] = 0;
         m_nmiss[v] = 0; m_trk = 1; m_te = v;
      end
   endfunction

   function automatic void m_miss(input logic [31:0] a, output bit el,
                                  output int eo, output logic [31:0] eb,
                                  output logic [3:0] es, output int ebc);
      int e;
      el = 0; eo = 0; eb = 0; es = 0; ebc = 0;
      if (!m_trk) return;
      e = m_te;
      if (!m_has2[e]) begin
         for (int k = 0; k < 4; k++) m_c[e][m_nmiss[e]][k] = a - shv(m_i1[e], k);
         m_nmiss[e]++;
         if (m_nmiss[e] == 4) m_trk = 0;
      end else if (m_nmiss[e] > 0) begin
         ebc = m_nmiss[e];
         for (int j = 0; j < m_nmiss[e]; j++) begin
            for (int k = 0; k < 4; k++) begin
               if (!el && m_c[e][j][k] == a - shv(m_i2[e], k)) begin
                  el = 1; eo = m_tag[e]; eb = m_c[e][j][k]; es = shcode(k); ebc = j + 1;
               end
            end
         end
         if (el) begin m_valid[e] = 0; m_has2[e] = 0; m_trk = 0; end
      end
   endfunction

   // One operation: drive for a cycle, wait for the scan, check results.
   task automatic do_op(input bit iv, input int o, input logic [15:0] ix,
                        input bit mv, input logic [31:0] ma, input string req);
      bit el; int eo; logic [31:0] eb; logic [3:0] es; int ebc; int bc; int c0;
      el = 0; eo = 0; eb = 0; es = 0; ebc = 0;
      if (iv) m_index(o, ix);
      else if (mv) m_miss(ma, el, eo, eb, es, ebc);
      c0 = lcnt;
      @(negedge clk);
      idx_valid = iv; idx_owner = o[3:0]; idx_value = ix;
      miss_valid = mv; miss_addr = ma;
      @(negedge clk);
      idx_valid = 0; miss_valid = 0;
      bc = 0;
      while (busy) begin bc++; @(negedge clk); end
      @(negedge clk);
      chk(bc == ebc, req, "busy cycles", bc, ebc);
      chk((lcnt - c0) == int'(el), req, "learn count", lcnt - c0, int'(el));
      if (el && (lcnt - c0) == 1) begin
         chk(l_owner == eo[3:0], req, "learn owner", l_owner, eo);
         chk(l_base == eb, req, "learn base", l_base, eb);
         chk(l_shift == es, req, "learn shift", l_shift, es);
      end
   endtask

   task automatic idx_ev(input int o, input logic [15:0] ix, input string req);
      do_op(1, o, ix, 0, 32'h0, req);
   endtask
   task automatic miss_ev(input logic [31:0] a, input string req);
      do_op(0, 0, 16'h0, 1, a, req);
   endtask

   // Miss that starts a scan, with an index event injected while busy (R8)
   task automatic miss_intrude(input logic [31:0] a, input int o, input logic [15:0] ix);
      bit el; int eo; logic [31:0] eb; logic [3:0] es; int ebc; int c0;
      m_miss(a, el, eo, eb, es, ebc);
      c0 = lcnt;
      @(negedge clk); miss_valid = 1; miss_addr = a;
      @(negedge clk); miss_valid = 0;
      chk(busy == 1'b1, "R8", "busy during scan", busy, 1);
      idx_valid = 1; idx_owner = o[3:0]; idx_value = ix;
      @(negedge clk); idx_valid = 0;
      while (busy) @(negedge clk);
      @(negedge clk);
      chk((lcnt - c0) == int'(el), "R8", "learn despite intrusion", lcnt - c0, int'(el));
      if (el && (lcnt - c0) == 1) chk(l_base == eb, "R8", "learn base", l_base, eb);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] base [16];
      logic [15:0] lidx [16];
      void'($urandom(32'd20240611));
      rst_n = 0; idx_valid = 0; miss_valid = 0;
      idx_owner = 0; idx_value = 0; miss_addr = 0;
      m_reset();
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(learn_valid == 1'b0, "R1", "learn after reset", learn_valid, 0);
      miss_ev(32'h1234_5678, "R1");            // nothing tracked: no effect

      // R2 R3 R4 R5: basic learn with shift 3
      idx_ev(1, 16'd10, "R2");
      miss_ev(32'h1000 + (32'd10 << 3), "R3");
      idx_ev(1, 16'd7, "R4");
      miss_ev(32'h1000 + (32'd7 << 3), "R5");
      chk(l_base == 32'h1000, "R5", "literal base", l_base, 32'h1000);
      chk(l_shift == 4'd3, "R5", "literal shift", l_shift, 3);

      // R3: negative index with arithmetic right shift
      idx_ev(2, 16'hFFF0, "R3");
      miss_ev(32'h2000 - 32'd2, "R3");
      idx_ev(2, 16'h0040, "R4");
      miss_ev(32'h2008, "R3");
      chk(l_base == 32'h2000, "R3", "neg-shift base", l_base, 32'h2000);
      chk(l_shift == 4'hD, "R3", "neg-shift code", l_shift, 4'hD);

      // R5: ties resolve to lowest shift
      idx_ev(11, 16'd0, "R2");
      miss_ev(32'h7700, "R3");
      idx_ev(11, 16'd0, "R4");
      miss_ev(32'h7700, "R5");
      chk(l_shift == 4'd2, "R5", "tie lowest shift", l_shift, 2);

      // R5: match found in slot 2, three busy cycles
      idx_ev(9, 16'd1, "R2");
      miss_ev(32'h6000_0000, "R3");
      miss_ev(32'h6100_0000, "R3");
      miss_ev(32'h6200_0000 + 32'd8, "R3");
      idx_ev(9, 16'd3, "R4");
      miss_ev(32'h6200_0000 + 32'd24, "R5");

      // R3: fifth miss is ignored, so its base is never learned
      idx_ev(8, 16'd1, "R2");
      for (int i = 0; i < 4; i++) miss_ev(32'h5000_0000 + i * 32'h100 + 32'd4, "R3");
      miss_ev(32'h5100_0004, "R3");
      idx_ev(8, 16'd2, "R4");
      miss_ev(32'h5100_0008, "R3");

      // R6: third index releases; a later matching miss learns nothing
      idx_ev(3, 16'd2, "R2");
      miss_ev(32'h3000_0020, "R3");
      idx_ev(3, 16'd6, "R4");
      miss_ev(32'hDEAD_0000, "R5");
      idx_ev(3, 16'd6, "R6");
      miss_ev(32'h3000_0060, "R6");
      idx_ev(3, 16'd2, "R6");

      // R9: index and miss together, the miss is dropped
      idx_ev(7, 16'd3, "R2");
      do_op(1, 7, 16'd4, 1, 32'h4000_000C, "R9");
      miss_ev(32'h4000_0010, "R9");

      // R8: index during a scan is ignored
      idx_ev(6, 16'd5, "R2");
      miss_ev(32'h4400_0014, "R3");
      idx_ev(6, 16'd9, "R4");
      miss_intrude(32'h4400_0024, 6, 16'd1);

      // R10: LRU eviction after a refresh
      idx_ev(12, 16'd1, "R10"); miss_ev(32'h8000_0004, "R10");
      idx_ev(13, 16'd1, "R10"); miss_ev(32'h8100_0004, "R10");
      idx_ev(14, 16'd1, "R10"); miss_ev(32'h8200_0004, "R10");
      idx_ev(15, 16'd1, "R10"); miss_ev(32'h8300_0004, "R10");
      idx_ev(12, 16'd2, "R10");
      idx_ev(5, 16'd1, "R10");
      idx_ev(14, 16'd2, "R10");
      miss_ev(32'h8200_0008, "R10");
      idx_ev(13, 16'd2, "R10");
      idx_ev(13, 16'd2, "R10");
      miss_ev(32'h8100_0008, "R10");

      // Random mix, R7 covers tracking of a single entry
      for (int o = 0; o < 16; o++) begin
         base[o] = 32'h9000_0000 + o * 32'h0001_0000;
         lidx[o] = 16'd1;
      end
      for (int n = 0; n < 400; n++) begin
         int o, r;
         logic [15:0] ix;
         o = int'($urandom % 6);
         r = int'($urandom % 12);
         if (r < 4) begin
            ix = 16'($urandom % 64);
            if ($urandom % 8 == 0) ix = 16'hFF00 | ix;
            lidx[o] = ix;
            idx_ev(o, ix, "R7");
         end else if (r < 10) begin
            miss_ev(base[o] + shv(lidx[o], int'($urandom % 4)), "R7");
         end else if (r == 10) begin
            miss_ev($urandom, "R7");
         end else begin
            ix = 16'($urandom % 64);
            lidx[o] = ix;
            do_op(1, o, ix, 1, base[o] + shv(ix, 0), "R9");
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule